// File: doc/BRIEF.md
# Watchdog-Supervised Mode Controller

This block decides the operating mode of a multi-channel power switch controller. It starts in sleep. A rising edge on the hardware reset pin, with the supplies good, wakes it into normal mode. A serial-interface watchdog then guards normal operation. The host must flip one designated bit of its serial frames often enough. If it stops, the controller drops into fail-safe. A failing logic supply does the same when its enable bit is set. A fault-summary flag overrides both normal and fail-safe and parks the controller in fault mode until the flag clears.

The watchdog counts only once it is armed. Arming takes a low-to-high edge on the wake pin, the reset pin or any channel input. A board strap turns off all timeouts. The serial decoder in front of the block supplies a one-cycle write strobe together with the value of the watchdog bit and of the separate recovery bit in that frame. The block tells the register file when to return to defaults, and tells the protection logic when to drop its latched faults. A ready flag models the start-up settling time after wake-up. A free-running cycle counter stands in for the internal oscillator.

Top module: `wdg_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 0 (sleep), and `nm_status`, `ready`, `reg_rst` and `flt_clr` are all 0. Mode codes are 0 sleep, 1 normal, 2 fail-safe and 3 fault.
- R2: In sleep, a rising edge on `hw_rst_in` with `sup_ok`=1 moves `mode` to 1 in the next cycle and pulses `reg_rst` in that same cycle. With `sup_ok`=0 the edge is ignored.
- R3: `ready` rises exactly READY_DLY cycles after `mode` becomes 1 on wake-up, and it stays high after that.
- R4: The watchdog is armed by a rising edge on `wake_in`, `hw_rst_in` or any bit of `ch_in`. Returning from fail-safe to normal disarms it. While it is disarmed, normal mode never times out.
- R5: The first write (`spi_wr`=1) after arming only records `spi_wd_bit`. A later write whose `spi_wd_bit` differs from the recorded value restarts the timeout count from zero. A write that carries the same value leaves the count running.
- R6: In normal mode, if TIMEOUT_CYC clock edges pass after arming or after the last accepted toggle with no new toggle, `mode` becomes 2. A toggle sampled on the expiring edge itself prevents the timeout.
- R7: While `wd_dis`=1, no timeout occurs. Setting `wd_dis`=1 during a fail-safe that a timeout caused returns `mode` to 1 on the next edge. It has no such effect on a fail-safe that the supply caused.
- R8: With `vdd_fail_en`=1, `vdd_fail`=1 in normal mode moves `mode` to 2 on the next edge. With `vdd_fail_en`=0, `vdd_fail` has no effect on the mode.
- R9: In fail-safe, a write with `spi_wdin`=1 while `vdd_fail`=0 returns `mode` to 1. A write with `spi_wdin`=0, or any write while `vdd_fail`=1, leaves `mode` at 2.
- R10: Entering fail-safe pulses both `reg_rst` and `flt_clr` for one cycle. Returning from fail-safe to normal pulses `flt_clr` only. Each pulse lasts exactly one cycle.
- R11: `nm_status` is 1 exactly when `mode` is 1.
- R12: `fault_sum`=1 in normal or fail-safe moves `mode` to 3 on the next edge. This takes priority over any fail-safe entry or exit in the same cycle. When `fault_sum` clears, `mode` goes back to the mode held before the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the timeout time base |
| rst_n | input | 1 | Active-low asynchronous reset |
| sup_ok | input | 1 | Both supplies above their undervoltage thresholds |
| vdd_fail | input | 1 | Logic supply out of range |
| vdd_fail_en | input | 1 | Lets `vdd_fail` force fail-safe |
| wd_dis | input | 1 | Strap that disables watchdog timeouts |
| wake_in | input | 1 | Wake pin, an arming source |
| hw_rst_in | input | 1 | Hardware reset pin, which wakes the block and arms the watchdog |
| ch_in | input | NCH | Channel input pins, arming sources |
| spi_wr | input | 1 | One-cycle strobe for a decoded serial write |
| spi_wd_bit | input | 1 | Value of the watchdog toggle bit in the frame |
| spi_wdin | input | 1 | Value of the fail-safe recovery bit in the frame |
| fault_sum | input | 1 | Summary of the active protection faults |
| mode | output | 2 | Current mode code |
| nm_status | output | 1 | Normal-mode status bit |
| reg_rst | output | 1 | Pulse that returns the control registers to defaults |
| flt_clr | output | 1 | Pulse that clears latched faults and autoretry state |
| ready | output | 1 | Start-up settling done |

## Verification
The sharpest collision is between an accepted watchdog toggle and the timeout firing on the same clock edge. The bench places a toggle exactly TIMEOUT_CYC edges after the previous one and expects normal mode to hold. One edge later it expects fail-safe. Randomized gaps around that boundary are scored by a bench function of the gap. A second collision is a fault-summary assertion in the same cycle as a supply-fail entry. There the bench expects fault mode and no latched-fault clear pulse.

// File: rtl/wdg_mode_ctrl.sv
module wdg_mode_ctrl #(
  parameter int NCH         = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int READY_DLY   = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sup_ok,
  input  logic           vdd_fail,
  input  logic           vdd_fail_en,
  input  logic           wd_dis,
  input  logic           wake_in,
  input  logic           hw_rst_in,
  input  logic [NCH-1:0] ch_in,
  input  logic           spi_wr,
  input  logic           spi_wd_bit,
  input  logic           spi_wdin,
  input  logic           fault_sum,
  output logic [1:0]     mode,
  output logic           nm_status,
  output logic           reg_rst,
  output logic           flt_clr,
  output logic           ready
);

  localparam int CW = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam int RW = $clog2(READY_DLY + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [RW-1:0] RDY_LAST = RW'(READY_DLY - 1);

  typedef enum logic [1:0] {M_SLEEP = 2'd0, M_NORM = 2'd1, M_FS = 2'd2, M_FAULT = 2'd3} mode_t;

  mode_t st, nxt, prev_st, nxt_prev;
  logic [NCH+1:0] pins, pins_q;
  logic [CW-1:0] cnt;
  logic [RW-1:0] rdy_cnt;
  logic armed, have_hist, hist_bit, fs_by_wd, rdy_run;
  logic enter_fs, back_norm, wake_up;

  assign pins = {hw_rst_in, wake_in, ch_in};

  wire arm_evt  = |(pins & ~pins_q);
  wire new_arm  = arm_evt && !armed;
  wire rst_rise = hw_rst_in && !pins_q[NCH+1];
  wire toggle   = spi_wr && armed && have_hist && (spi_wd_bit != hist_bit);
  wire to_hit   = armed && !wd_dis && (st == M_NORM) && (cnt == CNT_LAST) && !toggle;
  wire vfail    = vdd_fail && vdd_fail_en;
  wire exit_cmd = spi_wr && spi_wdin && !vdd_fail;

  always_comb begin
    nxt       = st;
    nxt_prev  = prev_st;
    enter_fs  = 1'b0;
    back_norm = 1'b0;
    wake_up   = 1'b0;
    case (st)
      M_SLEEP: if (rst_rise && sup_ok) begin
        nxt     = M_NORM;
        wake_up = 1'b1;
      end
      M_NORM: if (fault_sum) begin
        nxt      = M_FAULT;
        nxt_prev = M_NORM;
      end else if (to_hit || vfail) begin
        nxt      = M_FS;
        enter_fs = 1'b1;
      end
      M_FS: if (fault_sum) begin
        nxt      = M_FAULT;
        nxt_prev = M_FS;
      end else if ((fs_by_wd && wd_dis) || exit_cmd) begin
        nxt       = M_NORM;
        back_norm = 1'b1;
      end
      default: if (!fault_sum) nxt = prev_st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= M_SLEEP;
      prev_st   <= M_NORM;
      pins_q    <= '0;
      reg_rst   <= 1'b0;
      flt_clr   <= 1'b0;
      fs_by_wd  <= 1'b0;
      armed     <= 1'b0;
      have_hist <= 1'b0;
      hist_bit  <= 1'b0;
      cnt       <= '0;
    end else begin
      st      <= nxt;
      prev_st <= nxt_prev;
      pins_q  <= pins;
      reg_rst <= wake_up || enter_fs;
      flt_clr <= enter_fs || back_norm;
      if (enter_fs) fs_by_wd <= to_hit;

      if (back_norm)    armed <= 1'b0;
      else if (arm_evt) armed <= 1'b1;

      if (new_arm || back_norm) begin
        have_hist <= 1'b0;
      end else if (spi_wr && armed && !have_hist) begin
        have_hist <= 1'b1;
        hist_bit  <= spi_wd_bit;
      end else if (toggle) begin
        hist_bit <= spi_wd_bit;
      end

      if (new_arm || back_norm || toggle)
        cnt <= '0;
      else if (armed && !wd_dis && st == M_NORM && cnt != CNT_LAST)
        cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt <= '0;
      rdy_run <= 1'b0;
      ready   <= 1'b0;
    end else if (wake_up) begin
      rdy_cnt <= '0;
      rdy_run <= 1'b1;
    end else if (rdy_run && !ready) begin
      if (rdy_cnt == RDY_LAST) ready <= 1'b1;
      else rdy_cnt <= rdy_cnt + 1'b1;
    end
  end

  assign mode      = st;
  assign nm_status = (st == M_NORM);

  // R6: an unserviced expiry in normal mode leads to fail-safe
  a_r6_timeout_to_fs: assert property (@(posedge clk) disable iff (!rst_n)
    (to_hit && !fault_sum) |=> (mode == M_FS));

  // R7: with the strap set, normal mode cannot drop to fail-safe
  a_r7_strap_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NORM && wd_dis && !fault_sum && !(vdd_fail && vdd_fail_en)) |=> (mode == M_NORM));

  // R9: fail-safe is left only by a recovery write or the strap
  a_r9_fs_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FS && !fault_sum && !wd_dis && !(spi_wr && spi_wdin)) |=> (mode == M_FS));

  // R10: fail-safe entry clears faults and registers; pulses are single cycle
  a_r10_fs_entry_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == M_NORM && mode == M_FS) |-> (flt_clr && reg_rst));
  a_r10_rr_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst |=> !reg_rst);
  a_r10_fc_single: assert property (@(posedge clk) disable iff (!rst_n)
    flt_clr |=> !flt_clr);

  // R12: fault summary overrides normal and fail-safe
  a_r12_fault_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == M_NORM || mode == M_FS) && fault_sum) |=> (mode == M_FAULT));

endmodule

// File: tb/wdg_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module wdg_mode_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int TO  = 40;
  localparam int RDY = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sup_ok = 0, vdd_fail = 0, vdd_fail_en = 0, wd_dis = 0;
  logic wake_in = 0, hw_rst_in = 0;
  logic [NCH-1:0] ch_in = '0;
  logic spi_wr = 0, spi_wd_bit = 0, spi_wdin = 0, fault_sum = 0;
  logic [1:0] mode;
  logic nm_status, reg_rst, flt_clr, ready;

  int checks = 0, errors = 0, fc_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wdg_mode_ctrl #(.NCH(NCH), .TIMEOUT_CYC(TO), .READY_DLY(RDY)) dut_i (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .vdd_fail(vdd_fail),
    .vdd_fail_en(vdd_fail_en), .wd_dis(wd_dis), .wake_in(wake_in),
    .hw_rst_in(hw_rst_in), .ch_in(ch_in), .spi_wr(spi_wr),
    .spi_wd_bit(spi_wd_bit), .spi_wdin(spi_wdin), .fault_sum(fault_sum),
    .mode(mode), .nm_status(nm_status), .reg_rst(reg_rst),
    .flt_clr(flt_clr), .ready(ready));

  always @(negedge clk) if (flt_clr) fc_n++;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit b, bit wdin);
    @(negedge clk);
    spi_wr = 1; spi_wd_bit = b; spi_wdin = wdin;
    @(negedge clk);
    spi_wr = 0; spi_wdin = 0;
  endtask

  task automatic pin_rise(int p);
    @(negedge clk);
    if (p < NCH) ch_in[p] = 0; else if (p == NCH) wake_in = 0; else hw_rst_in = 0;
    @(negedge clk);
    if (p < NCH) ch_in[p] = 1; else if (p == NCH) wake_in = 1; else hw_rst_in = 1;
    @(negedge clk);
  endtask

  function automatic int exp_after_gap(int k);
    return (k <= TO - 2) ? 1 : 2;
  endfunction

  task automatic recover();
    wr(1'b0, 1'b1);
    chk("R9 recover", mode, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int fc0;
    void'($urandom(32'd7421));
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 mode", mode, 0);
    chk("R1 nm", nm_status, 0);
    chk("R1 ready", ready, 0);
    chk("R1 reg_rst", reg_rst, 0);
    chk("R1 flt_clr", flt_clr, 0);

    // R2: edge without good supply ignored
    pin_rise(NCH + 1);
    chk("R2 no wake without sup_ok", mode, 0);
    hw_rst_in = 0;
    sup_ok = 1;
    pin_rise(NCH + 1);                 // wake edge W, now at W+0.5
    chk("R2 wake to normal", mode, 1);
    chk("R2 reg_rst pulse", reg_rst, 1);
    chk("R11 nm in normal", nm_status, 1);
    tick(RDY - 1);
    chk("R3 ready not yet", ready, 0);
    tick(1);
    chk("R3 ready set", ready, 1);
    tick(TO - RDY - 1);                 // W+TO-0.5
    chk("R6 before expiry", mode, 1);
    tick(1);
    chk("R6 timeout to fail-safe", mode, 2);
    chk("R11 nm in fail-safe", nm_status, 0);
    chk("R10 reg_rst on entry", reg_rst, 1);
    chk("R10 flt_clr on entry", flt_clr, 1);
    tick(1);
    chk("R10 single pulse", flt_clr, 0);
    chk("R3 ready stays", ready, 1);

    // R9: exit conditions
    wr(1'b0, 1'b0);
    chk("R9 wdin=0 ignored", mode, 2);
    vdd_fail = 1;
    wr(1'b0, 1'b1);
    chk("R9 blocked by vdd_fail", mode, 2);
    vdd_fail = 0;
    wr(1'b0, 1'b1);
    chk("R9 exit to normal", mode, 1);
    chk("R10 flt_clr on exit", flt_clr, 1);
    chk("R10 no reg_rst on exit", reg_rst, 0);

    // R4: disarmed after recovery
    tick(2 * TO);
    chk("R4 disarmed no timeout", mode, 1);

    // R5: first frame after arming only records
    pin_rise(2);                         // arm at A, now A+0.5
    wr(1'b1, 1'b0);                      // sampled A+2, now A+2.5
    tick(TO - 3);
    chk("R5 first frame no restart, before", mode, 1);
    tick(1);
    chk("R5 first frame no restart, expiry", mode, 2);

    // R5: repeating the same value does not service
    recover();
    pin_rise(2);
    wr(1'b1, 1'b0);
    for (int i = 0; i < 5; i++) begin
      tick(6);
      wr(1'b1, 1'b0);
    end
    chk("R5 same value no service", mode, 2);

    // R6: toggle on the expiring edge wins; one later loses
    recover();
    pin_rise(NCH);
    wr(1'b1, 1'b0);
    wr(1'b0, 1'b0);                      // toggle at T
    tick(TO - 2);
    wr(1'b1, 1'b0);                      // sampled at T+TO
    chk("R6 toggle on expiry edge", mode, 1);
    tick(TO - 1);
    wr(1'b0, 1'b0);                      // sampled one edge late
    chk("R6 toggle one edge late", mode, 2);

    // R5/R6: random gaps around the boundary
    for (int it = 0; it < 20; it++) begin
      int k, p;
      bit b;
      recover();
      p = $urandom_range(0, NCH + 1);
      b = 1'($urandom_range(0, 1));
      pin_rise(p);
      wr(b, 1'b0);
      wr(~b, 1'b0);
      k = $urandom_range(TO - 6, TO + 2);
      tick(k);
      wr(b, 1'b0);
      chk("R6 random gap", mode, exp_after_gap(k));
      if (mode == 2'd1) begin
        tick(TO + 2);
        chk("R5 restarted count expires", mode, 2);
      end
    end

    // R7: strap disables timeouts and exits a watchdog fail-safe
    recover();
    pin_rise(0);
    wd_dis = 1;
    tick(2 * TO);
    chk("R7 strap blocks timeout", mode, 1);
    wd_dis = 0;
    tick(TO + 2);
    chk("R7 timeout after strap released", mode, 2);
    fc0 = fc_n;
    @(negedge clk) wd_dis = 1;
    @(negedge clk);
    chk("R7 strap exits fail-safe", mode, 1);
    tick(1);
    chk("R10 flt_clr on strap exit", fc_n - fc0, 1);
    wd_dis = 0;

    // R8: supply-fail entry gated by enable
    vdd_fail = 1;
    tick(5);
    chk("R8 disabled supply fail", mode, 1);
    @(negedge clk) vdd_fail_en = 1;
    @(negedge clk);
    chk("R8 supply fail to fail-safe", mode, 2);
    chk("R10 reg_rst on supply entry", reg_rst, 1);
    @(negedge clk) wd_dis = 1;
    @(negedge clk);
    tick(1);
    chk("R7 strap ignored for supply fail-safe", mode, 2);
    wd_dis = 0;
    wr(1'b0, 1'b1);
    chk("R9 blocked by vdd_fail again", mode, 2);
    vdd_fail = 0;
    wr(1'b0, 1'b1);
    chk("R9 exit after supply back", mode, 1);

    // R12: fault override and return
    @(negedge clk) fault_sum = 1;
    @(negedge clk);
    chk("R12 normal to fault", mode, 3);
    chk("R11 nm in fault", nm_status, 0);
    @(negedge clk) fault_sum = 0;
    @(negedge clk);
    chk("R12 fault back to normal", mode, 1);
    @(negedge clk) vdd_fail = 1;
    @(negedge clk);
    chk("R8 fail-safe again", mode, 2);
    @(negedge clk) fault_sum = 1;
    @(negedge clk);
    chk("R12 fail-safe to fault", mode, 3);
    vdd_fail = 0;
    @(negedge clk) fault_sum = 0;
    @(negedge clk);
    chk("R12 fault back to fail-safe", mode, 2);
    recover();
    tick(2);
    fc0 = fc_n;
    @(negedge clk) begin fault_sum = 1; vdd_fail = 1; end
    @(negedge clk);
    chk("R12 fault beats supply entry", mode, 3);
    tick(2);
    chk("R12 no clear pulse on fault", fc_n - fc0, 0);
    vdd_fail = 0;
    @(negedge clk) fault_sum = 0;
    @(negedge clk);
    chk("R12 back to normal", mode, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule